// File: doc/BRIEF.md
# Synchronous Two-Port RAM with Selectable Collision Result

This block is a single-clock memory with one write port and one read port. Both ports sample their addresses on the rising clock edge. Read data comes out of a register one edge after the address is presented, so no combinational path runs from the read address to the data output.

A build-time parameter decides what a read returns when it targets the same word that is written on the same edge. There are three choices:
- the word stored before the write;
- the word being written;
- no defined value, which costs no extra logic.

The storage array always gives the stored word. The write-data result is made by a small forwarding stage beside the array. That stage registers an address-match flag and a copy of the write data, then selects between that copy and the array output.

Reset only clears the forwarding stage. The storage array ignores reset completely: its contents survive it, and writes still land while reset is active.

Top module: `rdw_ram`

## Requirements
- R1: The read data for an address presented before a rising edge appears on `rdata_o` just after that edge. Changing `raddr_i` between edges does not change `rdata_o`.
- R2: A word is stored only on a rising edge where `we_i` is 1. An edge with `we_i` at 0 leaves the addressed word unchanged, whatever `wdata_i` holds.
- R3: With `RDW_MODE` set to `RDW_OLD`, a read on the same edge and at the same address as a write returns the word held before that write.
- R4: With `RDW_MODE` set to `RDW_NEW`, a read on the same edge and at the same address as a write returns the word being written.
- R5: When `we_i` is 0, a read returns the stored word in every mode, even if `waddr_i` equals `raddr_i`.
- R6: Asserting `rst_ni` low does not clear or alter any stored word.
- R7: A write issued while `rst_ni` is low is still stored.
- R8: With `RDW_MODE` set to `RDW_DONTCARE`, reads that do not collide with a write return the stored word, as in the other modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for both ports |
| rst_ni | input | 1 | Active-low asynchronous reset of the forwarding stage only |
| we_i | input | 1 | Write enable |
| waddr_i | input | ADDR_W | Write address |
| wdata_i | input | DATA_W | Write data |
| raddr_i | input | ADDR_W | Read address |
| rdata_o | output | DATA_W | Registered read data |

## Verification
The assertions assume that the write address and write data are known whenever `we_i` is high outside reset. The stimulus drives every input to a defined value from time zero, and it fills every word before any read result is compared.

The stability and old-data properties only judge cycles where the previous output was already known. Random stimulus forces roughly a third of its cycles to collide, in all three modes. It also never makes a same-address collision while reset is low, because the forwarding register is held clear then.

// File: rtl/rdw_pkg.sv
package rdw_pkg;
  typedef enum logic [1:0] {
    RDW_OLD      = 2'd0,
    RDW_NEW      = 2'd1,
    RDW_DONTCARE = 2'd2
  } rdw_mode_e;
endpackage

// File: rtl/rdw_store.sv
// Storage array with registered read; collisions always return the prior word.
module rdw_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  // no reset here: contents and ports are independent of rst_ni
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rd_q <= mem_q[raddr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/rdw_bypass.sv
// Forwarding stage: substitutes the written word on a same-edge address match.
module rdw_bypass #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  input  logic [DATA_W-1:0] arr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic              hit_q;
  logic [DATA_W-1:0] fwd_q;
  logic              live_q;

  // compare uses the same sampled addresses the array sees
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      fwd_q  <= '0;
      live_q <= 1'b0;
    end else begin
      hit_q  <= we_i && (waddr_i == raddr_i);
      fwd_q  <= wdata_i;
      live_q <= 1'b1;
    end
  end

  assign rdata_o = hit_q ? fwd_q : arr_i;

  // R4: a collision on the previous edge yields that edge's write data
  a_r4_new_on_collision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(we_i && (waddr_i == raddr_i)) |-> rdata_o == $past(wdata_i));
endmodule

// File: rtl/rdw_ram.sv
module rdw_ram #(
  parameter int                DATA_W   = 16,
  parameter int                ADDR_W   = 4,
  parameter rdw_pkg::rdw_mode_e RDW_MODE = rdw_pkg::RDW_NEW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] arr_q;

  rdw_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (we_i),
    .waddr_i (waddr_i),
    .wdata_i (wdata_i),
    .raddr_i (raddr_i),
    .rdata_o (arr_q)
  );

  generate
    if (RDW_MODE == rdw_pkg::RDW_NEW) begin : g_new
      rdw_bypass #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bypass (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (we_i),
        .waddr_i (waddr_i),
        .wdata_i (wdata_i),
        .raddr_i (raddr_i),
        .arr_i   (arr_q),
        .rdata_o (rdata_o)
      );
    end else begin : g_plain
      // old-data and don't-care both take the array result directly
      assign rdata_o = arr_q;
    end
  endgenerate

  // cycles since reset, saturating, used only to bound $past depth
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R2: a write must carry defined address and data
  a_r2_write_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> !$isunknown({waddr_i, wdata_i}));

  // R5: two quiet edges reading one address leave the output unchanged
  a_r5_quiet_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) && !$past(we_i) && !$past(we_i, 2) &&
    ($past(raddr_i) == $past(raddr_i, 2)) && !$isunknown($past(rdata_o))
    |-> $stable(rdata_o));

  generate
    if (RDW_MODE == rdw_pkg::RDW_OLD) begin : g_old_chk
      // R3: colliding read equals the prior read of that word when nothing wrote in between
      a_r3_old_on_collision: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd2) && $past(we_i && (waddr_i == raddr_i)) && !$past(we_i, 2) &&
        ($past(raddr_i) == $past(raddr_i, 2)) && !$isunknown($past(rdata_o))
        |-> rdata_o == $past(rdata_o));
    end
  endgenerate
endmodule

// File: tb/rdw_ram_tb.sv
`timescale 1ns/1ps
module rdw_ram_tb;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] waddr = '0;
  logic [AW-1:0] raddr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_new, rd_old, rd_dc;

  logic [DW-1:0] shadow [DEPTH];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rdw_ram #(.DATA_W(DW), .ADDR_W(AW), .RDW_MODE(rdw_pkg::RDW_NEW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .waddr_i(waddr),
    .wdata_i(wdata), .raddr_i(raddr), .rdata_o(rd_new));
  rdw_ram #(.DATA_W(DW), .ADDR_W(AW), .RDW_MODE(rdw_pkg::RDW_OLD)) u_dut_old (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .waddr_i(waddr),
    .wdata_i(wdata), .raddr_i(raddr), .rdata_o(rd_old));
  rdw_ram #(.DATA_W(DW), .ADDR_W(AW), .RDW_MODE(rdw_pkg::RDW_DONTCARE)) u_dut_dc (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .waddr_i(waddr),
    .wdata_i(wdata), .raddr_i(raddr), .rdata_o(rd_dc));

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one edge of traffic; checks all three variants against the shadow model
  task automatic step(input logic w, input logic [AW-1:0] wa, input logic [AW-1:0] ra,
                      input logic [DW-1:0] wd, input bit chk, input string tag);
    logic [DW-1:0] e_old, e_new;
    bit col;
    @(negedge clk);
    we = w; waddr = wa; raddr = ra; wdata = wd;
    e_old = shadow[ra];
    col   = w && (wa == ra);
    e_new = col ? wd : e_old;
    if (w) shadow[wa] = wd;
    @(posedge clk); #1;
    if (chk) begin
      if (col) begin
        check({tag, " R3 old-data collision"}, rd_old, e_old);
        check({tag, " R4 new-data collision"}, rd_new, e_new);
      end else begin
        check({tag, " new-mode read"}, rd_new, e_new);
        check({tag, " old-mode read"}, rd_old, e_old);
        check({tag, " R8 dont-care read"}, rd_dc, e_old);
      end
    end
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] prev;
    void'($urandom(32'd17));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // fill every word so reads compare against defined data
    for (int a = 0; a < DEPTH; a++)
      step(1'b1, AW'(a), AW'(a + 1), DW'(16'h1000 + a * 16'h0111), 1'b0, "fill");

    // R1: output changes only at the edge after the read address
    step(1'b0, '0, 4'd7, '0, 1'b1, "R1");
    prev = shadow[7];
    @(negedge clk); we = 1'b0; raddr = 4'd3; #1;
    check("R1 no combinational read", rd_new, prev);
    @(posedge clk); #1;
    check("R1 data after edge", rd_new, shadow[3]);

    // R2: write enable low leaves the word unchanged
    step(1'b0, 4'd5, 4'd0, 16'hDEAD, 1'b1, "R2");
    step(1'b0, '0, 4'd5, '0, 1'b1, "R2");
    check("R2 word kept", rd_new, 16'h1000 + 5 * 16'h0111);

    // R3/R4: directed collisions
    step(1'b1, 4'd6, 4'd6, 16'hBEEF, 1'b1, "R3R4");
    step(1'b1, 4'd6, 4'd6, 16'hCAFE, 1'b1, "R3R4");
    check("R3 prior word on collision", rd_old, 16'hBEEF);
    check("R4 written word on collision", rd_new, 16'hCAFE);

    // R5: matching addresses without write enable
    step(1'b0, 4'd6, 4'd6, 16'h5555, 1'b1, "R5");
    check("R5 new mode stored word", rd_new, 16'hCAFE);
    check("R5 old mode stored word", rd_old, 16'hCAFE);

    // R6/R7: reset keeps contents and still accepts writes
    @(negedge clk); rst_ni = 1'b0;
    step(1'b1, 4'd9, 4'd2, 16'h9999, 1'b0, "R7");
    @(negedge clk); rst_ni = 1'b1;
    step(1'b0, '0, 4'd9, '0, 1'b1, "R7");
    check("R7 write during reset", rd_new, 16'h9999);
    step(1'b0, '0, 4'd2, '0, 1'b1, "R6");
    check("R6 word survives reset", rd_old, 16'h1000 + 2 * 16'h0111);

    // random traffic with forced collisions
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] ra, wa;
      ra = AW'($urandom);
      wa = ($urandom % 3 == 0) ? ra : AW'($urandom);
      step(1'(($urandom % 4) != 0), wa, ra, DW'($urandom), 1'b1, "rand");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule